// File: doc/BRIEF.md
# Absolute Gray Code Track Merger

This block turns a set of separately digitized optical tracks into one absolute position word. Its inputs are a stack of coarse code-track bits, a quadrature pair from a fine sine/cosine track, and a few interpolated fine bits. The output is a registered Gray word. The coarse tracks come from comparators whose switching points drift by up to a count with mechanical and optical tolerance. Taken as they are, those tracks can make the merged code glitch at the coarse transitions.

With correction enabled, the block treats the quadrature pair as a 2-bit phase. Only in the two mid-cycle phases, where no coarse transition can occur, does it take the coarse reading. It converts that reading to a binary count of quadrature cycles. Across the cycle boundary it carries that count up or down by the phase wrap, and the raw coarse bits are ignored there. The corrected upper word is the Gray encoding of the count and the phase. It therefore changes by exactly one bit per step. With correction disabled, the raw coarse bits are passed through. The interpolated fine bits are never corrected. Every input crosses a reset-cleared synchronizer before use.

Top module: `gray_track_merger`

## Requirements
- R1: A synchronous active-high reset clears `word_o` to zero. It stays zero while reset is held, whatever the inputs are.
- R2: The lowest FINE_W bits of `word_o` always equal `fine_i`, uncorrected, in both modes.
- R3: Bit FINE_W of `word_o` always equals `sin_bit_i`, the lowest bit of the coarse Gray code, in both modes.
- R4: With `corr_en_i` = 0, bits [WORD_W-1:FINE_W+1] of `word_o` equal `coarse_i`, where `coarse_i[j]` is track j+1 and the top bit is the MSB.
- R5: The phase is {cos, sin^cos}, so (sin,cos) = 00,10,11,01 are phases 0,1,2,3. With `corr_en_i` = 1, `word_o` bits above the fine bits are the (COARSE_W+1)-bit Gray code of the true count. This holds when every coarse track switches within one count of its ideal point.
- R6: With correction on, a coarse reading taken in phase 0 or 3 has no effect on `word_o`.
- R7: With correction on, a phase step from 3 to 0 advances the count of quadrature cycles by one. A step from 0 to 3 moves it back by one. Either step changes the upper word in exactly one bit.
- R8: A change on any input reaches `word_o` on the third rising clock edge after it is applied: two synchronizer stages and one output register.
- R9: The count of quadrature cycles wraps modulo 2^(COARSE_W-1) in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| coarse_i | input | COARSE_W | Raw coarse track bits; bit j is track j+1 |
| sin_bit_i | input | 1 | Digitized sine channel, lowest coarse Gray bit |
| cos_bit_i | input | 1 | Digitized cosine channel, 90 degrees from sine |
| fine_i | input | FINE_W | Interpolated fine bits, MSB first below the sine bit |
| corr_en_i | input | 1 | 1 enables track correction, 0 bypasses it |
| word_o | output | COARSE_W+1+FINE_W | Merged absolute Gray word |

## Verification
The bench builds the block with COARSE_W = 5 and FINE_W = 4, which gives 64 coarse counts and 1024 fine positions. At that size every position is visited forward, backward, and across both wrap points. Each coarse track switches early or late by one count in a pattern that varies per track. In a separate sweep the coarse tracks carry arbitrary values in phases 0 and 3. The bypass sweep, the latency edge count and the reset with nonzero inputs complete the coverage.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

    localparam int PHASE_W = 2;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/gcm_sync.sv
module gcm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d;
    logic [STAGES-1:0][W-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gcm_phase.sv
module gcm_phase
    import gcm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sin_i,
    input  logic               cos_i,
    output logic [PHASE_W-1:0] phase_o,
    output step_e              step_o,
    output logic               window_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] prev;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic [PHASE_W-1:0] cur;

    always_comb begin
        cur      = {cos_i, sin_i ^ cos_i};
        st_d     = st_q;
        st_d.prev = cur;
        step_o   = STEP_HOLD;
        if (st_q.prev == 2'd3 && cur == 2'd0) begin
            step_o = STEP_UP;
        end else if (st_q.prev == 2'd0 && cur == 2'd3) begin
            step_o = STEP_DOWN;
        end
        window_o = (cur == 2'd1) || (cur == 2'd2);
        phase_o  = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gcm_track.sv
module gcm_track
    import gcm_pkg::*;
#(
    parameter int UPPER_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [UPPER_W-1:0] raw_upper_i,
    input  logic               window_i,
    input  step_e              step_i,
    output logic [UPPER_W-1:0] count_d_o
);

    typedef struct packed {
        logic [UPPER_W-1:0] count;
    } state_t;

    state_t st_d;
    state_t st_q;
    logic [UPPER_W-1:0] raw_bin;

    always_comb begin
        raw_bin[UPPER_W-1] = raw_upper_i[UPPER_W-1];
        for (int i = UPPER_W - 2; i >= 0; i--) begin
            raw_bin[i] = raw_bin[i+1] ^ raw_upper_i[i];
        end

        st_d = st_q;
        if (window_i) begin
            st_d.count = raw_bin;
        end else begin
            case (step_i)
                STEP_UP:   st_d.count = st_q.count + 1'b1;
                STEP_DOWN: st_d.count = st_q.count - 1'b1;
                default:   st_d.count = st_q.count;
            endcase
        end
        count_d_o = st_d.count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gray_track_merger.sv
module gray_track_merger
    import gcm_pkg::*;
#(
    parameter int COARSE_W    = 11,
    parameter int FINE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [COARSE_W-1:0]          coarse_i,
    input  logic                         sin_bit_i,
    input  logic                         cos_bit_i,
    input  logic [FINE_W-1:0]            fine_i,
    input  logic                         corr_en_i,
    output logic [COARSE_W+FINE_W:0]     word_o
);

    localparam int GRAY_W  = COARSE_W + 1;
    localparam int UPPER_W = GRAY_W - PHASE_W;
    localparam int WORD_W  = GRAY_W + FINE_W;
    localparam int SYNC_W  = COARSE_W + FINE_W + 3;

    logic [SYNC_W-1:0]   sync_in;
    logic [SYNC_W-1:0]   sync_out;
    logic [COARSE_W-1:0] coarse_s;
    logic [FINE_W-1:0]   fine_s;
    logic                sin_s;
    logic                cos_s;
    logic                corr_s;

    logic [PHASE_W-1:0]  phase;
    step_e               step;
    logic                window;
    logic [UPPER_W-1:0]  count_d;

    assign sync_in = {corr_en_i, cos_bit_i, sin_bit_i, coarse_i, fine_i};

    gcm_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign fine_s   = sync_out[FINE_W-1:0];
    assign coarse_s = sync_out[FINE_W +: COARSE_W];
    assign sin_s    = sync_out[FINE_W + COARSE_W];
    assign cos_s    = sync_out[FINE_W + COARSE_W + 1];
    assign corr_s   = sync_out[FINE_W + COARSE_W + 2];

    gcm_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .sin_i    (sin_s),
        .cos_i    (cos_s),
        .phase_o  (phase),
        .step_o   (step),
        .window_o (window)
    );

    gcm_track #(
        .UPPER_W (UPPER_W)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .raw_upper_i (coarse_s[COARSE_W-1:1]),
        .window_i    (window),
        .step_i      (step),
        .count_d_o   (count_d)
    );

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } out_t;

    out_t               out_d;
    out_t               out_q;
    logic [GRAY_W-1:0]  pos_bin;
    logic [GRAY_W-1:0]  pos_gray;

    always_comb begin
        pos_bin  = {count_d, phase};
        pos_gray = pos_bin ^ (pos_bin >> 1);
        out_d    = out_q;
        if (corr_s) begin
            out_d.word = {pos_gray, fine_s};
        end else begin
            out_d.word = {coarse_s, sin_s, fine_s};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o = out_q.word;

endmodule

// File: rtl/gcm_checker.sv
module gcm_checker
    import gcm_pkg::*;
#(
    parameter int COARSE_W = 11,
    parameter int FINE_W   = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [COARSE_W+FINE_W:0]   word,
    input logic [FINE_W-1:0]          fine_s,
    input logic [COARSE_W-1:0]        coarse_s,
    input logic                       sin_s,
    input logic                       corr_s,
    input logic [PHASE_W-1:0]         phase,
    input step_e                      step
);

    localparam int WORD_W = COARSE_W + FINE_W + 1;

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> word == '0); // R1

    AST_FINE_PASS: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0) |-> word[FINE_W-1:0] == $past(fine_s)); // R2

    AST_SIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0) |-> word[FINE_W] == $past(sin_s)); // R3

    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (rst)
        (age_q != 2'd0 && !$past(corr_s)) |-> word[WORD_W-1:FINE_W+1] == $past(coarse_s)); // R4

    AST_HOLD_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(corr_s) && $past(corr_s, 2) && $past(phase) == $past(phase, 2)
         && ($past(phase) == 2'd0 || $past(phase) == 2'd3))
        |-> $stable(word[WORD_W-1:FINE_W])); // R6

    AST_WRAP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && $past(corr_s) && $past(corr_s, 2) && $past(step) != STEP_HOLD)
        |-> $countones(word[WORD_W-1:FINE_W] ^ $past(word[WORD_W-1:FINE_W])) == 1); // R7

endmodule

bind gray_track_merger gcm_checker #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
) u_checker (
    .clk      (clk),
    .rst      (rst),
    .word     (word_o),
    .fine_s   (fine_s),
    .coarse_s (coarse_s),
    .sin_s    (sin_s),
    .corr_s   (corr_s),
    .phase    (phase),
    .step     (step)
);

// File: tb/tb_gray_track_merger.sv
module tb_gray_track_merger;

    localparam int CW     = 5;
    localparam int FW     = 4;
    localparam int GW     = CW + 1;
    localparam int WW     = CW + 1 + FW;
    localparam int CNT    = 1 << GW;
    localparam int NPOS   = CNT << FW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] coarse_i = '0;
    logic          sin_bit_i = 1'b0;
    logic          cos_bit_i = 1'b0;
    logic [FW-1:0] fine_i = '0;
    logic          corr_en_i = 1'b1;
    logic [WW-1:0] word_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [WW-1:0] exp_word;

    always #2.5 clk = ~clk;

    gray_track_merger #(
        .COARSE_W    (CW),
        .FINE_W      (FW),
        .SYNC_STAGES (2)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .coarse_i  (coarse_i),
        .sin_bit_i (sin_bit_i),
        .cos_bit_i (cos_bit_i),
        .fine_i    (fine_i),
        .corr_en_i (corr_en_i),
        .word_o    (word_o)
    );

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    // mode 0: exact tracks, 1: tracks off by up to one count, 2: junk in phases 0 and 3
    task automatic set_inputs(input int p, input int mode, input bit corr);
        int c;
        int f;
        int g;
        c = (p >> FW) % CNT;
        f = p % (1 << FW);
        g = c ^ (c >> 1);
        fine_i    = FW'(f);
        sin_bit_i = g[0];
        cos_bit_i = c[1];
        corr_en_i = corr;
        for (int k = 1; k <= CW; k++) begin
            int d;
            int cc;
            int gb;
            d  = (mode == 1) ? (((c + k) % 3) - 1) : 0;
            cc = (c + d + CNT) % CNT;
            gb = ((cc ^ (cc >> 1)) >> k) & 1;
            if (mode == 2 && k >= 2 && ((c % 4) == 0 || (c % 4) == 3)) begin
                gb = ((c * 37 + k * 11 + f) >> 2) & 1;
            end
            coarse_i[k-1] = gb[0];
        end
        exp_word = corr ? WW'((g << FW) | f) : {coarse_i, g[0], fine_i};
    endtask

    task automatic apply(input int p, input int mode, input bit corr, input string tag);
        set_inputs(p, mode, corr);
        repeat (3) @(posedge clk);
        #1;
        check("R2", {{(WW-FW){1'b0}}, word_o[FW-1:0]}, {{(WW-FW){1'b0}}, exp_word[FW-1:0]});
        check("R3", {{(WW-1){1'b0}}, word_o[FW]}, {{(WW-1){1'b0}}, exp_word[FW]});
        check(tag, word_o, exp_word);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] old_word;
        // R1: reset holds the word at zero even with live inputs
        set_inputs(37 << FW | 5, 0, 1'b1);
        rst = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check("R1", word_o, '0);
        set_inputs(0, 0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", word_o, '0);

        // R8: change reaches the output on the third edge, not before
        old_word = word_o;
        set_inputs(1 << FW, 0, 1'b1);
        repeat (2) @(posedge clk);
        #1;
        check("R8", word_o, old_word);
        @(posedge clk);
        #1;
        check("R8", word_o, exp_word);

        // R5: forward sweep, tracks offset by up to one count
        for (int p = (1 << FW); p < NPOS; p++) apply(p, 1, 1'b1, "R5");
        // R9: forward wrap of the count
        apply(0, 1, 1'b1, "R9");
        // R9: backward wrap of the count
        apply(NPOS - 1, 1, 1'b1, "R9");
        // R7: full backward sweep
        for (int p = NPOS - 2; p >= 0; p--) apply(p, 1, 1'b1, "R7");
        // R6: junk on coarse tracks in phases 0 and 3
        for (int p = 0; p < NPOS; p++) apply(p, 2, 1'b1, "R6");
        for (int p = NPOS - 1; p >= 0; p--) apply(p, 2, 1'b1, "R6");
        // R4: bypass passes raw tracks
        for (int p = 0; p < NPOS; p++) apply(p, 1, 1'b0, "R4");
        // R5: correction re-enabled mid-sweep
        for (int p = NPOS - 1; p >= NPOS - 200; p--) apply(p, 1, 1'b1, "R5");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule